// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Logic

This block is the control and status core of a PC-style real-time clock. It runs directly from a 32.768 kHz time base. A 15-bit prescaler produces a once-per-second update cycle and a programmable periodic tick. A short update-in-progress window comes before every seconds increment. Seconds, minutes and hours are kept in either BCD or binary. At each update the new time is compared against three alarm registers. Three event flags are gated by their own enables into a master request that drives the interrupt line.

Software reaches the registers through an indexed byte port. A strobe loads the index from the data bus. Later strobes write or read the register at that index. The read data always shows the register at the current index. A read strobe matters only at the flag register, where it clears the flags.

Top module: `rtc_irq_core`

## Requirements
- R1: After reset, index 0x0A reads 0x20, index 0x0B reads 0x02, index 0x0C reads 0x00, index 0x0D reads 0x80, and irq_o is low.
- R2: A pulse on idx_we_i loads wdata_i into the index register. A pulse on dat_we_i writes wdata_i to the register at the current index. rdata_o shows that register in the same cycle. Indices 0, 2 and 4 hold seconds, minutes and hours. Indices 1, 3 and 5 hold the matching alarms. Every index other than 0–5 and 0x0A–0x0D reads 0x00.
- R3: Rate code k = index 0x0A bits 3:0. For k in 3..15 the periodic flag (index 0x0C bit 6) sets every 2^(k-1) time-base cycles. Code 1 gives 32 cycles, code 2 gives 64 cycles, and code 0 never sets the flag.
- R4: The prescaler counts only when index 0x0A bits 6:4 equal 010. Any other value holds it at zero. After it is released, the first update comes exactly 32768 cycles later, and no periodic flag is set while it is held.
- R5: With index 0x0B bit 7 clear, the time advances once every 32768 counting cycles. Seconds and minutes wrap 59 to 0 and carry into the next field. Hours wrap 23 to 0. The fields use BCD when index 0x0B bit 2 is 0 and binary when it is 1.
- R6: Index 0x0A bit 7 (update in progress) is high for exactly 8 cycles just before an update. It falls in the same cycle that the update flag (index 0x0C bit 4) sets.
- R7: While index 0x0B bit 7 is set, the time fields do not change, update in progress stays low, and the update flag is not set.
- R8: The alarm flag (index 0x0C bit 5) sets at an update only if the new seconds, minutes and hours all equal their alarm registers.
- R9: Index 0x0C bit 7 is set when any flag among bits 6, 5 and 4 is set while its enable is set. The enables are index 0x0B bits 6, 5 and 4, in that order. Bits 3:0 read as zero. irq_o follows bit 7.
- R10: A pulse on dat_re_i at index 0x0C returns the current value and clears all of its flags, so irq_o falls afterwards.
- R11: Writes to index 0x0C, to index 0x0D, and to index 0x0A bit 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz time base; also clocks the register port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Load index from wdata_i |
| dat_we_i | input | 1 | Write wdata_i to the indexed register |
| dat_re_i | input | 1 | Read strobe (clears flags at index 0x0C) |
| wdata_i | input | 8 | Write data or index |
| rdata_o | output | 8 | Indexed register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that only one of the three strobes is high in any cycle. They also assume that a time field is written only while the prescaler is held, so a write never lands on the update edge. The bench follows this: every access is a single-cycle pulse, and every time and alarm field is preset under a prescaler hold before counting restarts. Update timing is measured from the release of the hold, so the cycle counts it expects are exact.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned IX_CTLA = 32'h0A;
  localparam int unsigned IX_CTLB = 32'h0B;
  localparam int unsigned IX_FLAG = 32'h0C;
  localparam int unsigned IX_STAT = 32'h0D;
  localparam int unsigned N_FLD   = 3;

  // {carry, next value}; carry set when wrapping from the limit
  function automatic logic [8:0] step_field(byte_t v, int unsigned lim, logic bin);
    byte_t enc;
    enc = bin ? 8'(lim) : {4'(lim / 10), 4'(lim % 10)};
    if (v == enc) return {1'b1, 8'h00};
    if (bin) return {1'b0, v + 8'd1};
    if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'h0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_div.sv
module rtc_div #(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned UIP_LEAD = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] dv_sel_i,
  input  logic [3:0] rate_i,
  output logic       pi_tick_o,
  output logic       sec_tick_o,
  output logic       uip_win_o
);
  localparam logic [DIV_W-1:0] CNT_MAX   = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] UIP_START = DIV_W'((2 ** DIV_W) - UIP_LEAD);

  logic [DIV_W-1:0] cnt_q, mask;
  logic [3:0] eff;
  logic run;

  assign run = (dv_sel_i == 3'b010);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end

  // shortest intervals are not reachable from the base; alias them
  always_comb begin
    case (rate_i)
      4'd1:    eff = 4'd6;
      4'd2:    eff = 4'd7;
      default: eff = rate_i;
    endcase
    mask = (DIV_W'(1) << (eff - 4'd1)) - DIV_W'(1);
  end

  assign pi_tick_o  = run && (rate_i != 4'd0) && ((cnt_q & mask) == mask);
  assign sec_tick_o = run && (cnt_q == CNT_MAX);
  assign uip_win_o  = run && (cnt_q >= UIP_START);

  assert_held_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic                 bin_i,
  input  logic                 wr_i,
  input  logic [2:0]           wr_idx_i,
  input  byte_t                wdata_i,
  output logic [2*N_FLD-1:0][7:0] regs_o,
  output logic                 alarm_o
);
  logic [N_FLD:0]   inc_en;
  logic [N_FLD-1:0] match;

  assign inc_en[0] = 1'b1;

  for (genvar i = 0; i < N_FLD; i++) begin : g_fld
    localparam int unsigned LIM = (i == N_FLD - 1) ? 23 : 59;
    byte_t val_q, al_q, nxt;
    logic [8:0] st;

    assign st            = step_field(val_q, LIM, bin_i);
    assign inc_en[i+1]   = inc_en[i] & st[8];
    assign nxt           = inc_en[i] ? st[7:0] : val_q;
    assign match[i]      = (nxt == al_q);
    assign regs_o[2*i]   = val_q;
    assign regs_o[2*i+1] = al_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
        al_q  <= '0;
      end else begin
        if (wr_i && wr_idx_i == 3'(2*i))     val_q <= wdata_i;
        else if (upd_i)                      val_q <= nxt;
        if (wr_i && wr_idx_i == 3'(2*i + 1)) al_q  <= wdata_i;
      end
    end
  end

  assign alarm_o = upd_i & (&match);

  assert_sec_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_i) |=> (regs_o[0] != $past(regs_o[0])));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_i) |=> $stable(regs_o));
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] set_i,    // {periodic, alarm, update}
  input  logic       rd_clr_i,
  input  logic [2:0] en_i,
  output logic [2:0] flag_o,
  output logic       irqf_o
);
  logic [2:0] flag_q;

  // a new event in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (rd_clr_i ? 3'b000 : flag_q) | set_i;
  end

  assign flag_o = flag_q;
  assign irqf_o = |(flag_q & en_i);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set_i == 3'b000) |=> (flag_q == 3'b000));
endmodule

// File: rtl/rtc_irq_core.sv
module rtc_irq_core
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DIV_W    = 15,
  parameter int unsigned UIP_LEAD = 8,
  parameter int unsigned IDX_W    = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_we_i,
  input  logic       dat_we_i,
  input  logic       dat_re_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic [IDX_W-1:0] idx_q;
  logic [6:0] ctla_q;
  logic [7:0] ctlb_q;
  logic pi_tick, sec_tick, uip_win, uip, upd, alarm, irqf, rd_clr, fld_wr;
  logic [2:0] flags;
  logic [2*N_FLD-1:0][7:0] fld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ctla_q <= 7'h20;
      ctlb_q <= 8'h02;
    end else begin
      if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
      if (dat_we_i && idx_q == IDX_W'(IX_CTLA)) ctla_q <= wdata_i[6:0];
      if (dat_we_i && idx_q == IDX_W'(IX_CTLB)) ctlb_q <= wdata_i;
    end
  end

  assign uip    = uip_win & ~ctlb_q[7];
  assign upd    = sec_tick & ~ctlb_q[7];
  assign fld_wr = dat_we_i && (idx_q < IDX_W'(2*N_FLD));
  assign rd_clr = dat_re_i && (idx_q == IDX_W'(IX_FLAG));

  rtc_div #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD)) i_div (
    .clk_i, .rst_ni,
    .dv_sel_i  (ctla_q[6:4]),
    .rate_i    (ctla_q[3:0]),
    .pi_tick_o (pi_tick),
    .sec_tick_o(sec_tick),
    .uip_win_o (uip_win)
  );

  rtc_time i_time (
    .clk_i, .rst_ni,
    .upd_i   (upd),
    .bin_i   (ctlb_q[2]),
    .wr_i    (fld_wr),
    .wr_idx_i(idx_q[2:0]),
    .wdata_i (wdata_i),
    .regs_o  (fld),
    .alarm_o (alarm)
  );

  rtc_flags i_flags (
    .clk_i, .rst_ni,
    .set_i   ({pi_tick, alarm, upd}),
    .rd_clr_i(rd_clr),
    .en_i    (ctlb_q[6:4]),
    .flag_o  (flags),
    .irqf_o  (irqf)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (idx_q < IDX_W'(2*N_FLD))          rdata_o = fld[idx_q[2:0]];
    else if (idx_q == IDX_W'(IX_CTLA))    rdata_o = {uip, ctla_q};
    else if (idx_q == IDX_W'(IX_CTLB))    rdata_o = ctlb_q;
    else if (idx_q == IDX_W'(IX_FLAG))    rdata_o = {irqf, flags, 4'h0};
    else if (idx_q == IDX_W'(IX_STAT))    rdata_o = 8'h80;
  end

  assign irq_o = irqf;

  assert_no_pf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctla_q[3:0] == 4'd0 && !flags[2]) |=> !flags[2]);
endmodule

// File: tb/test_rtc_irq_core.sv
module test_rtc_irq_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic idx_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_irq_core i_rtc_irq_core (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .dat_we_i(dat_we),
    .dat_re_i(dat_re), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int per(int c);
    if (c == 1) return 32;
    if (c == 2) return 64;
    return 1 << (c - 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(int a);
    idx_we = 1; wdata = 8'(a); @(negedge clk); idx_we = 0;
  endtask
  task automatic wr(int a, int d);
    set_idx(a); dat_we = 1; wdata = 8'(d); @(negedge clk); dat_we = 0;
  endtask
  task automatic peek(int a, output int v);
    set_idx(a); v = rdata;
  endtask
  task automatic pulse_re();
    dat_re = 1; @(negedge clk); dat_re = 0;
  endtask
  task automatic rd(int a, output int v);
    set_idx(a); v = rdata; pulse_re();
  endtask
  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 40000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000 - 5000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 1 exp 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n, n1, ucnt, prev, hi;
    int rv [6];
    v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(8'h0A, v); check("R1 ctla", v, 8'h20);
    peek(8'h0B, v); check("R1 ctlb", v, 8'h02);
    peek(8'h0C, v); check("R1 flag", v, 8'h00);
    peek(8'h0D, v); check("R1 stat", v, 8'h80);
    check("R1 irq", irq, 0);

    // R2 random write/read-back with prescaler held
    wr(8'h0A, 8'h60);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 6; i++) begin rv[i] = $urandom_range(0, 255); wr(i, rv[i]); end
      for (int i = 0; i < 6; i++) begin peek(i, v); check("R2 field", v, rv[i]); end
      n = $urandom_range(0, 255); wr(8'h0B, n); peek(8'h0B, v); check("R2 ctlb", v, n);
    end
    wr(8'h0B, 8'h02);
    peek(8'h06, v); check("R2 unmapped 06", v, 0);
    peek(8'h20, v); check("R2 unmapped 20", v, 0);

    // R11 read-only bits
    wr(8'h0A, 8'hE0); peek(8'h0A, v); check("R11 ctla bit7", v, 8'h60);
    wr(8'h0C, 8'hFF); peek(8'h0C, v); check("R11 flag", v, 8'h00);
    wr(8'h0D, 8'h00); peek(8'h0D, v); check("R11 stat", v, 8'h80);

    // R4 held prescaler: no periodic flag
    wr(8'h0A, 8'h63); rd(8'h0C, v); repeat (50) @(negedge clk);
    rd(8'h0C, v); check("R4 held no pf", v, 8'h00);

    // R9 flag without enable, R10 clear-on-read
    wr(8'h0A, 8'h23); repeat (20) @(negedge clk); wr(8'h0A, 8'h20);
    rd(8'h0C, v); check("R9 pf no enable", v, 8'h40);
    check("R9 irq low", irq, 0);
    rd(8'h0C, v); check("R10 cleared", v, 8'h00);
    wr(8'h0B, 8'h42); wr(8'h0A, 8'h23); repeat (20) @(negedge clk); wr(8'h0A, 8'h20);
    check("R9 irq high", irq, 1);
    rd(8'h0C, v); check("R9 pf enabled", v, 8'hC0);
    check("R10 irq dropped", irq, 0);

    // R3 periodic intervals: directed then random
    for (int k = 0; k < 6; k++) begin
      int c;
      c = (k == 0) ? 3 : (k == 1) ? 1 : (k == 2) ? 2 : $urandom_range(4, 9);
      wr(8'h0A, 8'h20 | c); set_idx(8'h0C); pulse_re();
      wait_irq(n1); pulse_re(); wait_irq(n);
      check($sformatf("R3 rate %0d", c), n + 1, per(c));
    end
    wr(8'h0A, 8'h20); rd(8'h0C, v);
    repeat (300) @(negedge clk);
    check("R3 rate0 irq", irq, 0);
    rd(8'h0C, v); check("R3 rate0 flag", v, 8'h00);

    // R5/R6/R8 BCD update with alarm hit
    wr(8'h0B, 8'h32); wr(8'h0A, 8'h60);
    wr(0, 8'h59); wr(2, 8'h59); wr(4, 8'h00);
    wr(1, 8'h00); wr(3, 8'h00); wr(5, 8'h01);
    rd(8'h0C, v);
    wr(8'h0A, 8'h20);
    n = 0; ucnt = 0; prev = 0;
    while (!irq && n < 40000) begin
      prev = rdata[7]; if (rdata[7]) ucnt++;
      @(negedge clk); n++;
    end
    check("R4 R5 update period", n, 32768);
    check("R6 uip length", ucnt, 8);
    check("R6 uip before", prev, 1);
    check("R6 uip fell", rdata[7], 0);
    rd(8'h0C, v); check("R8 alarm hit", v, 8'hB0);
    peek(0, v); check("R5 sec", v, 8'h00);
    peek(2, v); check("R5 min", v, 8'h00);
    peek(4, v); check("R5 hour", v, 8'h01);

    // R5 binary hour wrap, R8 miss
    wr(8'h0B, 8'h36); wr(8'h0A, 8'h60);
    wr(0, 8'h3B); wr(2, 8'h3B); wr(4, 8'h17); wr(5, 8'h05);
    rd(8'h0C, v); wr(8'h0A, 8'h20); wait_irq(n);
    rd(8'h0C, v); check("R8 alarm miss", v, 8'h90);
    peek(0, v); check("R5 bin sec", v, 0);
    peek(2, v); check("R5 bin min", v, 0);
    peek(4, v); check("R5 bin hour", v, 0);

    // R5 BCD digit carry
    wr(8'h0B, 8'h12); wr(8'h0A, 8'h60);
    wr(0, 8'h09); wr(2, 8'h22); wr(4, 8'h03);
    rd(8'h0C, v); wr(8'h0A, 8'h20); wait_irq(n);
    rd(8'h0C, v); check("R5 bcd flags", v, 8'h90);
    peek(0, v); check("R5 bcd sec", v, 8'h10);
    peek(2, v); check("R5 bcd min", v, 8'h22);

    // R7 halt
    wr(8'h0B, 8'h92); wr(8'h0A, 8'h60); rd(8'h0C, v); wr(8'h0A, 8'h20);
    ucnt = 0; hi = 0;
    for (int k = 0; k < 32800; k++) begin
      if (rdata[7]) ucnt++;
      if (irq) hi = 1;
      @(negedge clk);
    end
    check("R7 no uip", ucnt, 0);
    check("R7 no irq", hi, 0);
    peek(0, v); check("R7 sec held", v, 8'h10);
    rd(8'h0C, v); check("R7 no uf", v, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule